// File: doc/BRIEF.md
# RTC Alarm Interrupt Router

This block takes the two alarm match pulses of a real-time clock and turns them into interrupt requests on two active-low, open-drain style pins. Each alarm pulse latches a sticky flag that stays set until software clears it. The interrupt pins are computed from these flags, two per-alarm enable bits and one mode bit.

The mode bit selects between two pin maps. In merged mode (mode = 0), both enabled alarms share interrupt A. The second pin then carries a square wave, which toggles on every rising edge of a tick input. In split mode (mode = 1), alarm 1 drives interrupt A and alarm 2 drives the second pin.

Software accesses the block through a simple register port. Address 0 holds the control bits and address 1 holds the status flags. Reads are combinational and writes take effect at the clock edge.

Top module: `rtc_irq_router`

## Requirements
- R1: After reset, the mode bit, both enables and both flags are 0, the square-wave level is 1, and both pins read 1 (released).
- R2: A one-cycle high on `alarm1_match` or `alarm2_match` sets the matching flag. The flag stays set through any number of later cycles that have no clear.
- R3: A write to address 1 with a 0 in bit 0 clears the alarm 1 flag, and a 0 in bit 1 clears the alarm 2 flag. A 1 in either bit leaves that flag unchanged.
- R4: If a match pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R5: With mode = 1, `int_a_n` is low exactly when the alarm 1 flag and its enable are both 1. `sqw_intb_n` is low exactly when the alarm 2 flag and its enable are both 1.
- R6: With mode = 0, `int_a_n` is low when either flag is set together with its own enable, and high otherwise.
- R7: With mode = 0, `sqw_intb_n` shows the square-wave level. That level inverts at the clock edge where `sq_tick` is sampled high after having been sampled low, and holds otherwise.
- R8: A flag whose enable is 0 has no effect on either pin. The flag can still be read back as set.
- R9: Address 0 reads and writes {mode, alarm 2 enable, alarm 1 enable} in bits [2:0]. Address 1 reads the alarm 2 flag in bit 1 and the alarm 1 flag in bit 0. All other read bits are 0.
- R10: The pins are combinational from registered state. After the edge that sets or clears a flag, or that changes a control bit, the pins reflect the new state in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm1_match | input | 1 | One-cycle alarm 1 match pulse |
| alarm2_match | input | 1 | One-cycle alarm 2 match pulse |
| sq_tick | input | 1 | Square-wave source tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| int_a_n | output | 1 | Interrupt A, active low |
| sqw_intb_n | output | 1 | Square wave or interrupt B, active low |

## Verification
Each stimulus is applied just after a falling edge and lands at the next rising edge. The flags, the control bits and the square-wave level all change at that edge. Because the pins and the read data are combinational from this state, every result is due one edge after its stimulus. The bench therefore compares the pins and the read data at every falling edge against a behavioural model that steps at the same rising edge. Same-cycle set-and-clear and the tick-edge timing are driven deliberately, so the comparison lands on the exact cycle where the flag or the wave must have moved.

// File: rtl/rtc_irq_router.sv
module rtc_irq_router #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alarm1_match,
  input  logic          alarm2_match,
  input  logic          sq_tick,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          int_a_n,
  output logic          sqw_intb_n
);
  localparam int PAD_W = DW - 3;

  logic mode, en2, en1;
  logic flag2, flag1;
  logic wave, tick_q;

  wire ctrl_wr = reg_we && !reg_addr;
  wire stat_wr = reg_we && reg_addr;
  wire rise    = sq_tick && !tick_q;
  wire unused_wdata = ^reg_wdata[DW-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 1'b0;
      en2  <= 1'b0;
      en1  <= 1'b0;
    end else if (ctrl_wr) begin
      mode <= reg_wdata[2];
      en2  <= reg_wdata[1];
      en1  <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag1 <= 1'b0;
      flag2 <= 1'b0;
    end else begin
      flag1 <= alarm1_match | (flag1 & ~(stat_wr & ~reg_wdata[0]));
      flag2 <= alarm2_match | (flag2 & ~(stat_wr & ~reg_wdata[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      wave   <= 1'b1;
    end else begin
      tick_q <= sq_tick;
      if (rise) wave <= ~wave;
    end
  end

  wire req1 = flag1 & en1;
  wire req2 = flag2 & en2;

  assign int_a_n    = ~(req1 | (~mode & req2));
  assign sqw_intb_n = mode ? ~req2 : wave;
  assign reg_rdata  = reg_addr ? {{(PAD_W + 1){1'b0}}, flag2, flag1}
                               : {{PAD_W{1'b0}}, mode, en2, en1};

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm1_match |=> flag1);
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag2 && !(reg_we && reg_addr && !reg_wdata[1])) |=> flag2);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm1_match && reg_we && reg_addr && !reg_wdata[0]) |=> flag1);
  assert_split_b_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !en2) |-> sqw_intb_n);
  assert_wave_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_tick && !tick_q) |=> !$stable(wave));
  assert_wave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_tick && !tick_q) |=> $stable(wave));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en1 && !en2) |-> int_a_n);
endmodule

// File: tb/tb_rtc_irq_router.sv
module tb_rtc_irq_router;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0;
  logic m1 = 0, m2 = 0, tick = 0, we = 0, addr = 0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd;
  logic ia_n, sb_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_irq_router #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .alarm1_match(m1), .alarm2_match(m2),
    .sq_tick(tick), .reg_we(we), .reg_addr(addr), .reg_wdata(wd),
    .reg_rdata(rd), .int_a_n(ia_n), .sqw_intb_n(sb_n));

  // behavioural model
  bit r_mode, r_e1, r_e2, r_f1, r_f2, r_wave = 1, r_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_mode = 0; r_e1 = 0; r_e2 = 0; r_f1 = 0; r_f2 = 0; r_wave = 1; r_prev = 0;
    end else begin
      if (tick && !r_prev) r_wave = !r_wave;
      r_prev = tick;
      if (we && !addr) begin r_mode = wd[2]; r_e2 = wd[1]; r_e1 = wd[0]; end
      if (we && addr && !wd[0]) r_f1 = 0;
      if (we && addr && !wd[1]) r_f2 = 0;
      if (m1) r_f1 = 1;
      if (m2) r_f2 = 1;
    end
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic ea, eb;
    logic [DW-1:0] er;
    ea = !((r_f1 && r_e1) || (!r_mode && r_f2 && r_e2));
    eb = r_mode ? !(r_f2 && r_e2) : r_wave;
    er = addr ? {6'b0, r_f2, r_f1} : {5'b0, r_mode, r_e2, r_e1};
    check(r_mode ? "R5 int_a" : "R6 int_a", {7'b0, ia_n}, {7'b0, ea});
    check(r_mode ? "R5 sqw_intb" : "R7 sqw_intb", {7'b0, sb_n}, {7'b0, eb});
    check("R9 rdata", rd, er);
  endtask

  task automatic cyc(bit a1, bit a2, bit t, bit w, bit ad, logic [DW-1:0] d);
    m1 = a1; m2 = a2; tick = t; we = w; addr = ad; wd = d;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n, bit ad);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, ad, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 int_a reset", {7'b0, ia_n}, 8'h01);
    check("R1 sqw reset", {7'b0, sb_n}, 8'h01);
    rst_n = 1;
    idle(1, 0);
    check("R1 ctrl reset", rd, 8'h00);
    idle(1, 1);
    check("R1 status reset", rd, 8'h00);
    // R8: flags set with enables off, pins stay high
    cyc(1, 1, 0, 0, 1, '0);
    check("R8 flags latched", rd, 8'h03);
    check("R8 int_a quiet", {7'b0, ia_n}, 8'h01);
    idle(3, 1);
    check("R2 sticky", rd, 8'h03);
    // R3: write ones has no effect
    cyc(0, 0, 0, 1, 1, 8'hFF);
    check("R3 write one keeps", rd, 8'h03);
    // R6 merged mode, enable alarm 2 only
    cyc(0, 0, 0, 1, 0, 8'h02);
    check("R10 int_a same cycle", {7'b0, ia_n}, 8'h00);
    // clear alarm 2 -> release at once (R10)
    cyc(0, 0, 0, 1, 1, 8'h01);
    check("R10 release on clear", {7'b0, ia_n}, 8'h01);
    check("R3 clear f2 only", rd, 8'h01);
    // square wave in merged mode R7
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 1, 0, 1, '0);
      cyc(0, 0, 1, 0, 1, '0);
      cyc(0, 0, 0, 0, 1, '0);
    end
    // R4 set wins over clear
    cyc(1, 0, 0, 1, 1, 8'h00);
    check("R4 set wins", rd, 8'h01);
    cyc(0, 1, 0, 1, 1, 8'h00);
    check("R4 set wins f2", rd, 8'h02);
    // split mode with both enables R5
    cyc(0, 0, 0, 1, 0, 8'h07);
    check("R5 intb low", {7'b0, sb_n}, 8'h00);
    check("R5 int_a high", {7'b0, ia_n}, 8'h01);
    cyc(1, 0, 1, 0, 1, '0);
    check("R5 int_a low", {7'b0, ia_n}, 8'h00);
    idle(2, 0);
    check("R9 ctrl read", rd, 8'h07);
    // disable alarm 1 in split mode R8
    cyc(0, 0, 0, 1, 0, 8'h06);
    check("R8 en1 off", {7'b0, ia_n}, 8'h01);
    cyc(0, 0, 0, 1, 1, 8'h00);
    check("R10 intb release", {7'b0, sb_n}, 8'h01);
    // back to merged, alarm 1 enabled, still int_a
    cyc(0, 0, 0, 1, 0, 8'h01);
    cyc(1, 0, 0, 0, 0, '0);
    check("R6 alarm1 merged", {7'b0, ia_n}, 8'h00);
    idle(4, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule